// File: doc/BRIEF.md
# Multi-glitch fault pulse sequencer

This block drives a glitch-enable strobe for clock-glitch fault injection. A host sets it up over an asynchronous serial line. Every parameter write is a pair of bytes on that line: an address byte and then a data byte. The parameter space is one byte map. Address 0 holds a global amplitude setting, which leaves the block as a registered byte so that downstream clock-shaping logic can use it. Behind address 0 sit up to 31 glitch descriptors of eight bytes each. Each descriptor gives a delay and a width, both counted in clock cycles.

A rising edge on the trigger input starts a replay of the descriptors in ascending order. For each descriptor the block waits its delay and then holds the glitch-enable output high for its width. The delay of the first glitch runs from the trigger. The delay of every later glitch runs from the end of the glitch before it. The replay stops after the last descriptor, or earlier at a descriptor whose width is zero. While a replay runs, the block ignores further trigger edges and parameter writes, and a busy output shows the replay in progress.

Top module: `glitch_seq_top`

## Requirements
- R1: The serial receiver takes 8 data bits, least significant bit first, with one start bit, one stop bit and no parity, at CLK_FREQ_HZ/BAUD_RATE clocks per bit. A byte whose stop bit samples low is discarded and does not advance the write protocol.
- R2: Received bytes pair up as address and then data. The data byte of each pair commits one write. Address 0x00 selects the amplitude byte.
- R3: The amplitude output comes from a register and resets to 0xE0. A written value below 0xE0 is stored as 0xE0, a value above 0xF0 is stored as 0xF0, and any value from 0xE0 to 0xF0 is stored unchanged.
- R4: Glitch n (n from 1) keeps its delay at addresses 8n-7 to 8n-4 and its width at addresses 8n-3 to 8n. Both fields are little-endian: the lowest address holds the least significant byte.
- R5: A write to any address above 8*NUM_GLITCH (0xF8 by default) changes neither the amplitude nor any descriptor.
- R6: If the trigger input rises between clock edges, the glitch-enable output first goes high after the (3+D1)-th following rising clock edge, where D1 is the first delay. It stays high for exactly W1 cycles.
- R7: After each glitch, glitch-enable stays low for exactly the next delay Dn and then stays high for Wn cycles. A delay of 0 makes the next glitch follow without any low cycle.
- R8: A descriptor whose width is 0 ends the replay. No later glitch plays, and done pulses for one cycle in the cycle in which the ended glitch would have started its delay. If the first width is 0, done pulses 3 cycles after the trigger and busy never rises.
- R9: When all NUM_GLITCH descriptors have played, done pulses for one cycle as glitch-enable falls.
- R10: Busy is high from the cycle after the trigger is taken until the cycle in which glitch-enable last falls, and it is low on reset. A write committed while busy is high is dropped.
- R11: Each rising edge of the trigger starts exactly one replay. A trigger held high does not restart the block, and a rising edge that arrives while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uart_rx_i | input | 1 | Serial configuration line, idle high |
| trigger_i | input | 1 | Asynchronous replay trigger, rising-edge sensitive |
| glitch_en_o | output | 1 | Glitch enable strobe |
| amplitude_o | output | 8 | Registered amplitude setting |
| busy_o | output | 1 | Replay in progress |
| done_o | output | 1 | One-cycle pulse when a replay ends |

## Verification
The bench builds the expected glitch-enable, busy and done waveforms from the delay and width lists alone. It compares them cycle by cycle over the whole replay and a tail after it. The descriptor sets mix zero and non-zero delays, so that back-to-back glitches are told apart from separated ones. Sets stopped early by a zero width show the early end apart from the full replay. A multi-byte delay checks the byte order. A sweep over small first delays and widths pins the trigger-to-glitch latency. A second trigger edge inside a replay, and writes sent during a long delay, must leave the waveform and the amplitude exactly as they were, and out-of-range and bad-stop-bit bytes must leave the parameters untouched.

// File: rtl/glitch_seq_pkg.sv
package glitch_seq_pkg;

  localparam int FIELD_BYTES = 4;
  localparam int DESC_BYTES  = 2 * FIELD_BYTES;
  localparam int CNT_W       = 8 * FIELD_BYTES;
  localparam int DESC_W      = 8 * DESC_BYTES;

  localparam logic [7:0] AMP_MIN = 8'hE0;
  localparam logic [7:0] AMP_MAX = 8'hF0;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_PULSE = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic logic [7:0] clamp_amp(input logic [7:0] v);
    if (v < AMP_MIN)      return AMP_MIN;
    else if (v > AMP_MAX) return AMP_MAX;
    else                  return v;
  endfunction

endpackage

// File: rtl/gs_uart_rx.sv
module gs_uart_rx
  import glitch_seq_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_i,
  output logic       byte_valid_o,
  output logic [7:0] byte_o
);

  localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 2;
  localparam logic [CW-1:0] FULL_M1 = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(CLKS_PER_BIT / 2 - 1);

  logic            rx_m, rx_s;
  rx_state_e       st_q;
  logic [CW-1:0]   tick_q;
  logic [2:0]      bit_q;
  logic [7:0]      shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_i;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= RX_IDLE;
      tick_q       <= '0;
      bit_q        <= '0;
      shift_q      <= '0;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
    end else begin
      byte_valid_o <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          tick_q <= '0;
          if (!rx_s) st_q <= RX_START;
        end
        RX_START: begin
          if (tick_q == HALF_M1) begin
            tick_q <= '0;
            bit_q  <= '0;
            st_q   <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (tick_q == FULL_M1) begin
            tick_q  <= '0;
            shift_q <= {rx_s, shift_q[7:1]};
            if (bit_q == 3'd7) st_q <= RX_STOP;
            else               bit_q <= bit_q + 1'b1;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (tick_q == FULL_M1) begin
            tick_q <= '0;
            st_q   <= RX_IDLE;
            if (rx_s) begin
              byte_valid_o <= 1'b1;
              byte_o       <= shift_q;
            end
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gs_cfg_writer.sv
module gs_cfg_writer
  import glitch_seq_pkg::*;
#(
  parameter int NUM_GLITCH = 31,
  parameter int IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             busy_i,
  output logic [7:0]       amp_o,
  output logic             we_o,
  output logic [IDX_W-1:0] waddr_o,
  output logic [2:0]       wlane_o,
  output logic [7:0]       wdata_o
);

  localparam logic [8:0] TOP_ADDR = 9'(DESC_BYTES * NUM_GLITCH);

  logic       have_addr_q;
  logic [7:0] addr_q;
  logic [7:0] offset;
  logic       commit;
  logic       in_map;

  assign offset  = addr_q - 8'd1;
  assign commit  = byte_valid_i && have_addr_q && !busy_i;
  assign in_map  = (addr_q != 8'd0) && ({1'b0, addr_q} <= TOP_ADDR);
  assign we_o    = commit && in_map;
  assign waddr_o = IDX_W'(offset >> 3);
  assign wlane_o = offset[2:0];
  assign wdata_o = byte_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_addr_q <= 1'b0;
      addr_q      <= '0;
      amp_o       <= AMP_MIN;
    end else begin
      if (byte_valid_i) begin
        have_addr_q <= !have_addr_q;
        if (!have_addr_q) addr_q <= byte_i;
      end
      if (commit && addr_q == 8'd0) amp_o <= clamp_amp(byte_i);
    end
  end

endmodule

// File: rtl/gs_param_mem.sv
module gs_param_mem
  import glitch_seq_pkg::*;
#(
  parameter int NUM_GLITCH = 31,
  parameter int IDX_W      = 5
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [2:0]        wlane_i,
  input  logic [7:0]        wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DESC_W-1:0] rdata_o
);

  for (genvar l = 0; l < DESC_BYTES; l++) begin : g_lane
    logic [7:0] lane_mem [NUM_GLITCH];

    always_ff @(posedge clk) begin
      if (we_i && wlane_i == 3'(l)) lane_mem[waddr_i] <= wdata_i;
      rdata_o[8*l +: 8] <= lane_mem[raddr_i];
    end
  end

endmodule

// File: rtl/gs_sequencer.sv
module gs_sequencer
  import glitch_seq_pkg::*;
#(
  parameter int NUM_GLITCH = 31,
  parameter int IDX_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_rise_i,
  input  logic [DESC_W-1:0] desc_i,
  output logic [IDX_W-1:0]  raddr_o,
  output logic              glitch_en_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_GLITCH - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] wid_q, wid_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_d;
  logic             load;
  logic [CNT_W-1:0] nxt_dly, nxt_wid;

  assign nxt_dly = desc_i[CNT_W-1:0];
  assign nxt_wid = desc_i[DESC_W-1:CNT_W];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wid_d   = wid_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    load    = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (trig_rise_i) begin
          idx_d = '0;
          load  = 1'b1;
        end
      end
      SEQ_WAIT: begin
        if (cnt_q == '0) begin
          state_d = SEQ_PULSE;
          cnt_d   = wid_q - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SEQ_PULSE: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (idx_q == LAST) begin
          state_d = SEQ_IDLE;
          idx_d   = '0;
          done_d  = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          load  = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase

    if (load) begin
      wid_d = nxt_wid;
      if (nxt_wid == '0) begin
        state_d = SEQ_IDLE;
        idx_d   = '0;
        done_d  = 1'b1;
      end else if (nxt_dly == '0) begin
        state_d = SEQ_PULSE;
        cnt_d   = nxt_wid - 1'b1;
      end else begin
        state_d = SEQ_WAIT;
        cnt_d   = nxt_dly - 1'b1;
      end
    end
  end

  // Prefetch: present the descriptor that follows the one being loaded.
  always_comb begin
    if (state_d == SEQ_IDLE || idx_d == LAST) raddr_o = '0;
    else                                      raddr_o = idx_d + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SEQ_IDLE;
      cnt_q       <= '0;
      wid_q       <= '0;
      idx_q       <= '0;
      glitch_en_o <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      wid_q       <= wid_d;
      idx_q       <= idx_d;
      glitch_en_o <= (state_d == SEQ_PULSE);
      busy_o      <= (state_d != SEQ_IDLE);
      done_o      <= done_d;
    end
  end

endmodule

// File: rtl/glitch_seq_top.sv
module glitch_seq_top
  import glitch_seq_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int BAUD_RATE   = 115_200,
  parameter int NUM_GLITCH  = 31
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       uart_rx_i,
  input  logic       trigger_i,
  output logic       glitch_en_o,
  output logic [7:0] amplitude_o,
  output logic       busy_o,
  output logic       done_o
);

  localparam int CLKS_PER_BIT = CLK_FREQ_HZ / BAUD_RATE;
  localparam int IDX_W        = (NUM_GLITCH > 1) ? $clog2(NUM_GLITCH) : 1;

  logic              rx_valid;
  logic [7:0]        rx_byte;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_waddr;
  logic [2:0]        mem_wlane;
  logic [7:0]        mem_wdata;
  logic [IDX_W-1:0]  mem_raddr;
  logic [DESC_W-1:0] mem_rdata;
  logic [2:0]        trig_sh;
  logic              trig_rise;

  always_ff @(posedge clk) begin
    if (rst) trig_sh <= '0;
    else     trig_sh <= {trig_sh[1:0], trigger_i};
  end
  assign trig_rise = trig_sh[1] && !trig_sh[2];

  gs_uart_rx #(
    .CLKS_PER_BIT(CLKS_PER_BIT)
  ) u_rx (
    .clk         (clk),
    .rst         (rst),
    .rx_i        (uart_rx_i),
    .byte_valid_o(rx_valid),
    .byte_o      (rx_byte)
  );

  gs_cfg_writer #(
    .NUM_GLITCH(NUM_GLITCH),
    .IDX_W     (IDX_W)
  ) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .byte_valid_i(rx_valid),
    .byte_i      (rx_byte),
    .busy_i      (busy_o),
    .amp_o       (amplitude_o),
    .we_o        (mem_we),
    .waddr_o     (mem_waddr),
    .wlane_o     (mem_wlane),
    .wdata_o     (mem_wdata)
  );

  gs_param_mem #(
    .NUM_GLITCH(NUM_GLITCH),
    .IDX_W     (IDX_W)
  ) u_mem (
    .clk    (clk),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wlane_i(mem_wlane),
    .wdata_i(mem_wdata),
    .raddr_i(mem_raddr),
    .rdata_o(mem_rdata)
  );

  gs_sequencer #(
    .NUM_GLITCH(NUM_GLITCH),
    .IDX_W     (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .trig_rise_i(trig_rise),
    .desc_i     (mem_rdata),
    .raddr_o    (mem_raddr),
    .glitch_en_o(glitch_en_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

endmodule

// File: rtl/glitch_seq_chk.sv
module glitch_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       glitch_en,
  input logic       busy,
  input logic       done,
  input logic [7:0] amplitude
);

  a_r3_amp_in_range: assert property (@(posedge clk) disable iff (rst)
    amplitude >= 8'hE0 && amplitude <= 8'hF0);

  a_r10_glitch_needs_busy: assert property (@(posedge clk) disable iff (rst)
    glitch_en |-> busy);

  a_r10_amp_frozen_while_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(amplitude));

  a_r8_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !glitch_en));

  a_r9_end_flags_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

endmodule

bind glitch_seq_top glitch_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .glitch_en(glitch_en_o),
  .busy     (busy_o),
  .done     (done_o),
  .amplitude(amplitude_o)
);

// File: tb/tb_glitch_seq_top.sv
`timescale 1ns/1ps
module tb_glitch_seq_top;

  localparam int CLK_HZ = 50_000_000;
  localparam int CPB    = 16;
  localparam int BAUD   = CLK_HZ / CPB;
  localparam int NG     = 4;
  localparam int WINMAX = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic       trig = 1'b0;
  logic       glitch_en;
  logic [7:0] amplitude;
  logic       busy;
  logic       done;

  int checks = 0;
  int errors = 0;

  int g_dly [NG];
  int g_wid [NG];
  bit exp_en   [WINMAX];
  bit exp_busy [WINMAX];
  bit exp_done [WINMAX];
  int t_end;

  always #10 clk = ~clk;

  glitch_seq_top #(
    .CLK_FREQ_HZ(CLK_HZ),
    .BAUD_RATE  (BAUD),
    .NUM_GLITCH (NG)
  ) dut (
    .clk        (clk),
    .rst        (rst),
    .uart_rx_i  (rx_line),
    .trigger_i  (trig),
    .glitch_en_o(glitch_en),
    .amplitude_o(amplitude),
    .busy_o     (busy),
    .done_o     (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  task automatic send_byte(input logic [7:0] b, input bit good_stop);
    @(negedge clk);
    rx_line = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx_line = good_stop;
    repeat (CPB) @(negedge clk);
    rx_line = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    send_byte(a, 1'b1);
    send_byte(d, 1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_desc(input int n, input int d, input int w);
    for (int b = 0; b < 4; b++) begin
      wr(8'(1 + 8*n + b), 8'(d >> (8*b)));
      wr(8'(5 + 8*n + b), 8'(w >> (8*b)));
    end
    g_dly[n] = d;
    g_wid[n] = w;
  endtask

  task automatic build_expected();
    int  t;
    bit  ended;
    for (int k = 0; k < WINMAX; k++) begin
      exp_en[k] = 0; exp_busy[k] = 0; exp_done[k] = 0;
    end
    t = 3;
    ended = 0;
    for (int n = 0; n < NG; n++) begin
      if (!ended) begin
        if (g_wid[n] == 0) begin
          exp_done[t] = 1;
          ended = 1;
        end else begin
          for (int k = t + g_dly[n]; k < t + g_dly[n] + g_wid[n]; k++) exp_en[k] = 1;
          t = t + g_dly[n] + g_wid[n];
          if (n == NG - 1) begin
            exp_done[t] = 1;
            ended = 1;
          end
        end
      end
    end
    for (int k = 3; k < t; k++) exp_busy[k] = 1;
    t_end = t;
  endtask

  task automatic run_seq(input string req, input bit retrig);
    int win, bad_en, bad_busy, bad_done;
    build_expected();
    win = t_end + 20;
    bad_en = -1; bad_busy = -1; bad_done = -1;
    trig = 1'b1;
    for (int k = 1; k < win; k++) begin
      @(negedge clk);
      if (glitch_en !== exp_en[k] && bad_en < 0)   bad_en = k;
      if (busy !== exp_busy[k] && bad_busy < 0)    bad_busy = k;
      if (done !== exp_done[k] && bad_done < 0)    bad_done = k;
      if (retrig && k == 6) trig = 1'b0;
      if (retrig && k == 8) trig = 1'b1;
    end
    check(bad_en < 0, req, "glitch_en first mismatch cycle", bad_en, -1);
    check(bad_busy < 0, req, "busy first mismatch cycle", bad_busy, -1);
    check(bad_done < 0, req, "done first mismatch cycle", bad_done, -1);
    trig = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic amp_case(input logic [7:0] v);
    logic [7:0] expv;
    wr(8'h00, v);
    if (v < 8'hE0)      expv = 8'hE0;
    else if (v > 8'hF0) expv = 8'hF0;
    else                expv = v;
    check(amplitude == expv, "R3", "amplitude after write", amplitude, expv);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state (R3, R10)
    check(amplitude == 8'hE0, "R3", "reset amplitude", amplitude, 8'hE0);
    check(glitch_en == 1'b0, "R10", "reset glitch_en", glitch_en, 0);
    check(busy == 1'b0, "R10", "reset busy", busy, 0);
    check(done == 1'b0, "R10", "reset done", done, 0);

    // R2 / R3: amplitude writes at and around the bounds
    amp_case(8'hE5);
    amp_case(8'h00);
    amp_case(8'hDF);
    amp_case(8'hF0);
    amp_case(8'hF1);
    amp_case(8'hFF);
    amp_case(8'hE0);
    amp_case(8'hEC);
    check(amplitude == 8'hEC, "R2", "address 0 selects amplitude", amplitude, 8'hEC);

    // R1: bad stop bit byte discarded, pairing keeps waiting for data
    send_byte(8'h00, 1'b1);
    send_byte(8'hE9, 1'b0);
    repeat (4) @(negedge clk);
    check(amplitude == 8'hEC, "R1", "amplitude after bad-stop data", amplitude, 8'hEC);
    send_byte(8'hEB, 1'b1);
    repeat (4) @(negedge clk);
    check(amplitude == 8'hEB, "R1", "amplitude after good data", amplitude, 8'hEB);

    // R6 / R7 / R9: full replay with mixed zero and non-zero delays
    set_desc(0, 0, 1);
    set_desc(1, 1, 1);
    set_desc(2, 0, 2);
    set_desc(3, 5, 3);
    run_seq("R7", 1'b0);

    // R5: writes past the map must not alias into descriptors or amplitude
    wr(8'h21, 8'hFF);
    wr(8'h25, 8'hFF);
    wr(8'hFF, 8'h00);
    check(amplitude == 8'hEB, "R5", "amplitude after out-of-range writes", amplitude, 8'hEB);
    run_seq("R5", 1'b0);

    // R11 / R9: second trigger edge during a replay is ignored
    set_desc(0, 7, 2);
    set_desc(1, 0, 3);
    set_desc(2, 4, 1);
    set_desc(3, 1, 6);
    run_seq("R11", 1'b1);
    run_seq("R9", 1'b0);

    // R8: zero width in the second descriptor
    set_desc(0, 2, 4);
    set_desc(1, 3, 0);
    run_seq("R8", 1'b0);

    // R8: zero width in the first descriptor
    set_desc(0, 5, 0);
    run_seq("R8", 1'b0);

    // R4: multi-byte little-endian delay (0x105 = 261)
    set_desc(0, 1, 1);
    set_desc(1, 261, 2);
    set_desc(2, 0, 0);
    run_seq("R4", 1'b0);

    // R6: sweep of first delay and width
    set_desc(0, 0, 1);
    set_desc(1, 0, 0);
    for (int d = 0; d < 4; d++) begin
      for (int w = 1; w < 4; w++) begin
        wr(8'h01, 8'(d));
        wr(8'h05, 8'(w));
        g_dly[0] = d;
        g_wid[0] = w;
        run_seq("R6", 1'b0);
      end
    end

    // R10: writes during a long delay are dropped
    wr(8'h00, 8'hE8);
    set_desc(0, 900, 5);
    set_desc(1, 0, 0);
    fork
      run_seq("R10", 1'b0);
      begin
        repeat (20) @(negedge clk);
        wr(8'h00, 8'hE4);
        wr(8'h01, 8'h05);
      end
    join
    check(amplitude == 8'hE8, "R10", "amplitude after write while busy", amplitude, 8'hE8);
    run_seq("R10", 1'b0);

    finish_sim();
  end

endmodule